// File: doc/BRIEF.md
# Bus Clock Prescaler Tree

This block takes a single system clock and derives from it a family of clock-enable strobes. Each strobe is high for exactly one system-clock cycle per period of its derived rate. There is a high-speed bus stage, and two peripheral-bus stages that count the bus stage's strobes. Each peripheral-bus stage has a timer tap. An analog-converter stage counts the strobes of the second peripheral-bus stage, and a fixed system-timer tick comes straight from the system clock. Logic downstream qualifies its flops with these strobes, so every derived domain stays in the system clock domain.

Each stage's ratio is picked by an encoded select input. A stage samples its select only when its current count completes. A new setting therefore never shortens or duplicates a period. All derived strobes are combinational functions of the stage counters, so a strobe of a lower stage always coincides with a strobe of every stage above it. The reset input is asynchronous and active low, and its release is synchronised inside the block.

Top module: `bus_prescaler_tree`

## Requirements
- R1: While rst_n is low, every strobe output and ahb_sel_err are 0.
- R2: ahb_sel codes 0,1,2,3,4,5,6,7,8 make hclk_en pulse once every 1,2,4,8,16,64,128,256,512 system-clock cycles, each pulse one cycle wide.
- R3: ahb_sel code 9 is an illegal divide-by-32 request. It divides by 1, and ahb_sel_err is 1 in the cycle after the code is sampled and 0 otherwise. Codes 10 to 15 divide by 1 without raising ahb_sel_err.
- R4: apb1_sel and apb2_sel codes 0,1,2,3,4 set apb1_en and apb2_en to one pulse per 1,2,4,8,16 hclk_en pulses. Codes 5 to 7 mean 1. Every pulse coincides with an hclk_en pulse.
- R5: Each timer strobe (apb1_tim_en, apb2_tim_en) has the period of its peripheral-bus strobe when that stage's ratio is 1, and half that period otherwise. It fires with every peripheral-bus strobe and only on hclk_en cycles.
- R6: adc_sel codes 0,1,2,3 set adc_en to one pulse per 2,4,6,8 apb2_en pulses. Each adc_en pulse coincides with an apb2_en pulse.
- R7: systick_en pulses once every 8 system-clock cycles, whatever the other selects are.
- R8: A new select value takes effect only when the stage's current count completes. The period in progress keeps its old length, and the next period has the new length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ahb_sel | input | 4 | Bus stage ratio select |
| apb1_sel | input | 3 | First peripheral-bus ratio select |
| apb2_sel | input | 3 | Second peripheral-bus ratio select |
| adc_sel | input | 2 | Converter stage ratio select |
| hclk_en | output | 1 | Bus-rate strobe |
| apb1_en | output | 1 | First peripheral-bus strobe |
| apb1_tim_en | output | 1 | Timer strobe behind the first peripheral bus |
| apb2_en | output | 1 | Second peripheral-bus strobe |
| apb2_tim_en | output | 1 | Timer strobe behind the second peripheral bus |
| adc_en | output | 1 | Converter strobe |
| systick_en | output | 1 | Fixed divide-by-8 tick |
| ahb_sel_err | output | 1 | Illegal bus select flag |

## Verification
The bench measures the spacing of consecutive pulses on every strobe and compares it with periods computed from the selects.

Several kinds of setting are applied:
- A sweep of every bus code with the lower stages at their fastest isolates the bus decode.
- Sweeps of the peripheral and converter codes at a fixed bus ratio isolate those decodes. These sweeps also show whether the timer tap doubles only when its stage actually divides.
- Random mixed settings expose interactions between stages in the cascade.
- Directed cases cover the rest:
  - The illegal and unlisted codes.
  - A select change in the middle of a count, which separates a change taken at the count boundary from one taken at once.
  - A deep cascade, which checks that the ratios multiply.

// File: rtl/presc_tree_pkg.sv
package presc_tree_pkg;
  localparam int AHB_SEL_W = 4;
  localparam int APB_SEL_W = 3;
  localparam int ADC_SEL_W = 2;
  localparam int AHB_CW    = 9;
  localparam int APB_CW    = 4;
  localparam int ADC_CW    = ADC_SEL_W + 1;
  localparam logic [AHB_SEL_W-1:0] AHB_DIV32_CODE = 4'd9;

  // terminal count (ratio minus one) for the bus stage
  function automatic logic [AHB_CW-1:0] ahb_term(input logic [AHB_SEL_W-1:0] sel);
    logic [AHB_CW-1:0] t;
    case (sel)
      4'd1:    t = AHB_CW'(1);
      4'd2:    t = AHB_CW'(3);
      4'd3:    t = AHB_CW'(7);
      4'd4:    t = AHB_CW'(15);
      4'd5:    t = AHB_CW'(63);
      4'd6:    t = AHB_CW'(127);
      4'd7:    t = AHB_CW'(255);
      4'd8:    t = AHB_CW'(511);
      default: t = '0;
    endcase
    return t;
  endfunction

  function automatic logic [APB_CW-1:0] apb_term(input logic [APB_SEL_W-1:0] sel);
    logic [APB_CW-1:0] t;
    case (sel)
      3'd1:    t = APB_CW'(1);
      3'd2:    t = APB_CW'(3);
      3'd3:    t = APB_CW'(7);
      3'd4:    t = APB_CW'(15);
      default: t = '0;
    endcase
    return t;
  endfunction

  // ratios 2,4,6,8 -> terminal counts 1,3,5,7
  function automatic logic [ADC_CW-1:0] adc_term(input logic [ADC_SEL_W-1:0] sel);
    return {sel, 1'b1};
  endfunction
endpackage

// File: rtl/presc_stage.sv
module presc_stage #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic [CW-1:0] term_i,
  output logic          tick_o,
  output logic          half_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] term_q, term_d;
  logic          wrap;

  assign wrap   = tick_i && (cnt_q == term_q);
  assign tick_o = wrap;
  // mid-count tap: for term 0 it equals wrap, otherwise doubles the rate
  assign half_o = tick_i && (wrap || (cnt_q == (term_q >> 1)));

  always_comb begin
    cnt_d  = cnt_q;
    term_d = term_q;
    if (tick_i) begin
      if (wrap) begin
        cnt_d  = '0;
        term_d = term_i;
      end else begin
        cnt_d  = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      term_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      term_q <= term_d;
    end
  end
endmodule

// File: rtl/systick_gen.sv
module systick_gen #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick_o = run_i && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (run_i) begin
      if (cnt_q == LAST) cnt_d = '0;
      else               cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bus_prescaler_tree.sv
module bus_prescaler_tree
  import presc_tree_pkg::*;
#(
  parameter int SYSTICK_DIV = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AHB_SEL_W-1:0] ahb_sel,
  input  logic [APB_SEL_W-1:0] apb1_sel,
  input  logic [APB_SEL_W-1:0] apb2_sel,
  input  logic [ADC_SEL_W-1:0] adc_sel,
  output logic                 hclk_en,
  output logic                 apb1_en,
  output logic                 apb1_tim_en,
  output logic                 apb2_en,
  output logic                 apb2_tim_en,
  output logic                 adc_en,
  output logic                 systick_en,
  output logic                 ahb_sel_err
);
  logic [1:0] rs_q;
  logic       rst_sync_n;
  logic       run_q, run_d;
  logic       err_q, err_d;
  logic       ahb_half_unused;
  logic       adc_half_unused;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  assign run_d = 1'b1;
  assign err_d = (ahb_sel == AHB_DIV32_CODE);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      run_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      run_q <= run_d;
      err_q <= err_d;
    end
  end
  assign ahb_sel_err = err_q;

  presc_stage #(.CW(AHB_CW)) u_ahb (
    .clk(clk), .rst_n(rst_sync_n), .tick_i(run_q), .term_i(ahb_term(ahb_sel)),
    .tick_o(hclk_en), .half_o(ahb_half_unused)
  );

  presc_stage #(.CW(APB_CW)) u_apb1 (
    .clk(clk), .rst_n(rst_sync_n), .tick_i(hclk_en), .term_i(apb_term(apb1_sel)),
    .tick_o(apb1_en), .half_o(apb1_tim_en)
  );

  presc_stage #(.CW(APB_CW)) u_apb2 (
    .clk(clk), .rst_n(rst_sync_n), .tick_i(hclk_en), .term_i(apb_term(apb2_sel)),
    .tick_o(apb2_en), .half_o(apb2_tim_en)
  );

  presc_stage #(.CW(ADC_CW)) u_adc (
    .clk(clk), .rst_n(rst_sync_n), .tick_i(apb2_en), .term_i(adc_term(adc_sel)),
    .tick_o(adc_en), .half_o(adc_half_unused)
  );

  systick_gen #(.DIV(SYSTICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_sync_n), .run_i(run_q), .tick_o(systick_en)
  );
endmodule

// File: rtl/presc_tree_chk.sv
module presc_tree_chk #(
  parameter int DIV = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       arst_n,
  input logic [3:0] ahb_sel,
  input logic       hclk_en,
  input logic       apb1_en,
  input logic       apb1_tim_en,
  input logic       apb2_en,
  input logic       apb2_tim_en,
  input logic       adc_en,
  input logic       systick_en,
  input logic       ahb_sel_err
);
  logic       up_q;
  logic       seen_q;
  logic [4:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q   <= 1'b0;
      seen_q <= 1'b0;
      gap_q  <= '0;
    end else begin
      up_q <= 1'b1;
      if (systick_en) begin
        seen_q <= 1'b1;
        gap_q  <= '0;
      end else if (gap_q != 5'd31) begin
        gap_q  <= gap_q + 5'd1;
      end
    end
  end

  always @(negedge clk) begin
    if (!arst_n) begin
      assert_reset_quiet_R1: assert ({hclk_en, apb1_en, apb1_tim_en, apb2_en,
                                      apb2_tim_en, adc_en, systick_en, ahb_sel_err} == 8'h00);
    end
  end

  assert_err_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    up_q |-> (ahb_sel_err == $past(ahb_sel == 4'd9)));

  assert_apb1_in_hclk_R4: assert property (@(posedge clk) disable iff (!rst_n)
    apb1_en |-> hclk_en);

  assert_apb2_in_hclk_R4: assert property (@(posedge clk) disable iff (!rst_n)
    apb2_en |-> hclk_en);

  assert_tim1_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (apb1_en |-> apb1_tim_en) and (apb1_tim_en |-> hclk_en));

  assert_tim2_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (apb2_en |-> apb2_tim_en) and (apb2_tim_en |-> hclk_en));

  assert_adc_in_apb2_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adc_en |-> apb2_en);

  assert_tick_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && systick_en) |-> (gap_q == 5'(DIV - 1)));

  assert_tick_no_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> (gap_q < 5'(DIV)));
endmodule

bind bus_prescaler_tree presc_tree_chk #(.DIV(SYSTICK_DIV)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .arst_n(rst_n), .ahb_sel(ahb_sel),
  .hclk_en(hclk_en), .apb1_en(apb1_en), .apb1_tim_en(apb1_tim_en),
  .apb2_en(apb2_en), .apb2_tim_en(apb2_tim_en), .adc_en(adc_en),
  .systick_en(systick_en), .ahb_sel_err(ahb_sel_err)
);

// File: tb/sim_bus_prescaler_tree.sv
`timescale 1ns/1ps
module sim_bus_prescaler_tree;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] ahb_sel;
  logic [2:0] apb1_sel, apb2_sel;
  logic [1:0] adc_sel;
  logic hclk_en, apb1_en, apb1_tim_en, apb2_en, apb2_tim_en, adc_en, systick_en, ahb_sel_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  int last_c [7];
  int seen_c [7];
  int bad_c  [7];
  int badv_c [7];
  int expv   [7];
  bit chk_on = 1'b0;
  int cur_a = 1, cur_p1 = 1, cur_p2 = 1, cur_d = 2, cur_max = 8;

  always #2.5 clk = ~clk;

  bus_prescaler_tree u0 (
    .clk(clk), .rst_n(rst_n), .ahb_sel(ahb_sel), .apb1_sel(apb1_sel),
    .apb2_sel(apb2_sel), .adc_sel(adc_sel), .hclk_en(hclk_en), .apb1_en(apb1_en),
    .apb1_tim_en(apb1_tim_en), .apb2_en(apb2_en), .apb2_tim_en(apb2_tim_en),
    .adc_en(adc_en), .systick_en(systick_en), .ahb_sel_err(ahb_sel_err)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    logic [6:0] s;
    s = {systick_en, adc_en, apb2_tim_en, apb2_en, apb1_tim_en, apb1_en, hclk_en};
    for (int i = 0; i < 7; i++) begin
      if (s[i]) begin
        if (last_c[i] >= 0 && chk_on) begin
          seen_c[i]++;
          if (cyc - last_c[i] != expv[i]) begin
            bad_c[i]++;
            badv_c[i] = cyc - last_c[i];
          end
        end
        last_c[i] = cyc;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ahb_ratio(input int c);
    case (c)
      1: return 2;   2: return 4;   3: return 8;   4: return 16;
      5: return 64;  6: return 128; 7: return 256; 8: return 512;
      default: return 1;
    endcase
  endfunction

  function automatic int apb_ratio(input int c);
    return (c <= 4) ? (1 << c) : 1;
  endfunction

  function automatic int adc_ratio(input int c);
    return 2 * (c + 1);
  endfunction

  function automatic int tim_period(input int a, input int p);
    return (p == 1) ? a : a * p / 2;
  endfunction

  task automatic run_cfg(input int ac, input int p1c, input int p2c, input int dc);
    int ra, r1, r2, rd, nmax, settle;
    string names [7];
    names = '{"R2 hclk", "R4 apb1", "R5 tim1", "R4 apb2", "R5 tim2", "R6 adc", "R7 systick"};
    ra = ahb_ratio(ac); r1 = apb_ratio(p1c); r2 = apb_ratio(p2c); rd = adc_ratio(dc);
    @(posedge clk); #1;
    ahb_sel = 4'(ac); apb1_sel = 3'(p1c); apb2_sel = 3'(p2c); adc_sel = 2'(dc);
    expv[0] = ra; expv[1] = ra * r1; expv[2] = tim_period(ra, r1);
    expv[3] = ra * r2; expv[4] = tim_period(ra, r2); expv[5] = ra * r2 * rd; expv[6] = 8;
    nmax = 8;
    for (int i = 0; i < 7; i++) if (expv[i] > nmax) nmax = expv[i];
    settle = cur_max + cur_a + ((cur_p1 > cur_p2) ? cur_p1 : cur_p2) * ra
             + cur_d * ra * r2 + nmax + 8;
    repeat (settle) @(posedge clk);
    for (int i = 0; i < 7; i++) begin
      last_c[i] = -1; seen_c[i] = 0; bad_c[i] = 0; badv_c[i] = 0;
    end
    chk_on = 1'b1;
    repeat (2 * nmax + 4) @(posedge clk);
    chk_on = 1'b0;
    for (int i = 0; i < 7; i++)
      check(seen_c[i] > 0 && bad_c[i] == 0, names[i],
            (seen_c[i] == 0) ? -1 : badv_c[i], expv[i]);
    cur_a = ra; cur_p1 = r1; cur_p2 = r2; cur_d = rd; cur_max = nmax;
  endtask

  task automatic next_hclk(output int c);
    do @(negedge clk); while (!hclk_en);
    c = cyc;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int c0, c1, c2;
    void'($urandom(32'd4711));
    rst_n = 1'b0; ahb_sel = 4'd0; apb1_sel = 3'd0; apb2_sel = 3'd0; adc_sel = 2'd0;
    begin
      int quiet = 1;
      repeat (6) begin
        @(negedge clk);
        if ({hclk_en, apb1_en, apb1_tim_en, apb2_en, apb2_tim_en, adc_en,
             systick_en, ahb_sel_err} != 8'h00) quiet = 0;
      end
      check(quiet == 1, "R1 reset quiet", quiet, 1);
    end
    rst_n = 1'b1;

    run_cfg(0, 0, 0, 0);
    // R2: every bus code, lower stages fastest
    for (int a = 1; a <= 8; a++) run_cfg(a, 0, 0, 0);
    // R3: illegal and unlisted bus codes
    run_cfg(9, 0, 0, 0);
    check(ahb_sel_err == 1'b1, "R3 err on code 9", ahb_sel_err, 1);
    run_cfg(12, 0, 0, 0);
    check(ahb_sel_err == 1'b0, "R3 no err on code 12", ahb_sel_err, 0);
    // R4/R5: peripheral codes including unlisted ones
    for (int c = 0; c < 8; c++) run_cfg(1, c, 7 - c, 1);
    // R6: converter codes
    for (int d = 0; d < 4; d++) run_cfg(0, 1, 2, d);
    // R8: change in the middle of a count of 16
    run_cfg(4, 0, 0, 0);
    next_hclk(c0);
    repeat (3) @(negedge clk);
    ahb_sel = 4'd1;
    next_hclk(c1);
    next_hclk(c2);
    check(c1 - c0 == 16, "R8 old period kept", c1 - c0, 16);
    check(c2 - c1 == 2, "R8 new period", c2 - c1, 2);
    cur_a = 2;
    // deep cascade
    run_cfg(3, 4, 2, 3);
    // random mixed settings
    for (int k = 0; k < 6; k++)
      run_cfg(int'($urandom % 5), int'($urandom % 8), int'($urandom % 5), int'($urandom % 4));

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule